// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block decides which input of a twelve-input successive-approximation converter is sampled next, and in what order. When a start request is accepted it captures four settings: a 2-bit scan code, a channel select, a flag that reserves the top input as a voltage reference, and a flag for external-clock operation. It then issues one conversion at a time, as a channel number with a one-cycle start pulse. It waits for the converter's done strobe before it moves on.

Each 10-bit result is pushed into an ordered result store in the order of conversion. A read port pops results oldest first. Accepting a new start empties the store, so results can only be read after a sequence has produced them. A sticky completion flag rises together with the write of the last result. Start requests that arrive while a sequence is running are dropped.

Top module: `adc_scan_seq`

## Requirements
- R1: Scan code 2'b00 converts channels 0, 1, 2 and so on up to and including the selected channel, in ascending order, one conversion each.
- R2: A channel select above 11 (4'b1011) is treated as 11 in every scan code, so no conversion is ever issued on a channel above 11.
- R3: Scan code 2'b01 with the external-clock flag low converts the selected channel eight times back to back.
- R4: Scan code 2'b10 converts from channel 6 up to the selected channel in ascending order. If the selected channel is 6 or lower, only channel 6 is converted.
- R5: Scan code 2'b11 converts the selected channel exactly once.
- R6: When the reference flag is high, the ascending scans (codes 2'b00 and 2'b10) end at channel 10 at the latest, and channel 11 is never converted in them.
- R7: When the external-clock flag is high, scan code 2'b01 converts the selected channel once, the same as code 2'b11.
- R8: Results are read back in the order they were converted. `rd_valid` is high only while an unread result of the current sequence is held. A read with `rd_valid` low has no effect.
- R9: After reset, `conv_ch` is 0, and `conv_start`, `seq_done` and `rd_valid` are low.
- R10: `seq_done` is low from the cycle after a start is accepted, and it goes high in the cycle after the last result of the sequence is taken.
- R11: A start request while a sequence is running is ignored: the running sequence continues with its original settings, and no extra conversions are issued.
- R12: Every conversion gets a single-cycle `conv_start` pulse. The next pulse comes only after `conv_done` has returned a result for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a new scan sequence |
| cfg_scan | input | 2 | Scan code, captured when a start is accepted |
| cfg_chsel | input | 4 | Channel select, captured when a start is accepted |
| cfg_refpin | input | 1 | Top input reserved as reference |
| cfg_extclk | input | 1 | External-clock operation |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | Result strobe from the converter |
| conv_data | input | 10 | Conversion result |
| seq_done | output | 1 | Sticky completion flag for the sequence |
| rd_en | input | 1 | Pop the oldest result |
| rd_valid | output | 1 | An unread result is available |
| rd_data | output | 10 | Oldest unread result |

## Verification
The bench builds the block with its default parameters: twelve channels, an eight-fold repeat, channel 6 as the start of the upper scan, and a sixteen-entry store. These values let it reach the clamp of a select above 11, the reference exclusion at the top of both ascending scans, and the longest sequence (twelve results) without overflowing the store. The converter model returns each result tagged with the channel it was given and a running index. Any wrong channel order, a missing conversion or an extra conversion therefore shows up as a scoreboard mismatch.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    SCAN_UP  = 2'b00,
    SCAN_REP = 2'b01,
    SCAN_MID = 2'b10,
    SCAN_ONE = 2'b11
  } scan_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/scan_plan.sv
module scan_plan
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 12,
  parameter int CHW    = 4,
  parameter int REPEAT = 8,
  parameter int MIDCH  = 6,
  parameter int RW     = 4
) (
  input  logic [1:0]     scan,
  input  logic [CHW-1:0] sel,
  input  logic           refpin,
  input  logic           extclk,
  output logic [CHW-1:0] first,
  output logic [CHW-1:0] last,
  output logic [RW-1:0]  reps
);
  localparam logic [CHW-1:0] TOPCH = CHW'(NCH - 1);
  localparam logic [CHW-1:0] REFCH = CHW'(NCH - 2);
  localparam logic [CHW-1:0] MID   = CHW'(MIDCH);

  logic [CHW-1:0] sel_c;
  logic [CHW-1:0] top_multi;
  logic [CHW-1:0] up_end;

  always_comb begin
    sel_c     = (sel > TOPCH) ? TOPCH : sel;
    top_multi = refpin ? REFCH : TOPCH;
    up_end    = (sel_c > top_multi) ? top_multi : sel_c;
    first     = sel_c;
    last      = sel_c;
    reps      = RW'(1);
    case (scan_e'(scan))
      SCAN_UP: begin
        first = '0;
        last  = up_end;
      end
      SCAN_MID: begin
        first = MID;
        last  = (up_end < MID) ? MID : up_end;
      end
      SCAN_REP: reps = extclk ? RW'(1) : RW'(REPEAT);
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import adc_scan_pkg::*;
#(
  parameter int NCH = 12,
  parameter int CHW = 4,
  parameter int RW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic [CHW-1:0] plan_first,
  input  logic [CHW-1:0] plan_last,
  input  logic [RW-1:0]  plan_reps,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  output logic           res_wr,
  output logic           seq_clr,
  output logic           seq_done
);
  seq_state_e     st_q, st_d;
  logic [CHW-1:0] ch_q, ch_d, last_q, last_d;
  logic [RW-1:0]  reps_q, reps_d, rcnt_q, rcnt_d;
  logic           done_q, done_d;

  always_comb begin
    st_d    = st_q;
    ch_d    = ch_q;
    last_d  = last_q;
    reps_d  = reps_q;
    rcnt_d  = rcnt_q;
    done_d  = done_q;
    res_wr  = 1'b0;
    seq_clr = 1'b0;
    case (st_q)
      ST_IDLE: if (start_req) begin
        st_d    = ST_ISSUE;
        ch_d    = plan_first;
        last_d  = plan_last;
        reps_d  = plan_reps;
        rcnt_d  = plan_reps;
        done_d  = 1'b0;
        seq_clr = 1'b1;
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: if (conv_done) begin
        res_wr = 1'b1;
        if (rcnt_q > RW'(1)) begin
          rcnt_d = rcnt_q - RW'(1);
          st_d   = ST_ISSUE;
        end else if (ch_q == last_q) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          ch_d   = ch_q + CHW'(1);
          rcnt_d = reps_q;
          st_d   = ST_ISSUE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      last_q <= '0;
      reps_q <= RW'(1);
      rcnt_q <= RW'(1);
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      last_q <= last_d;
      reps_q <= reps_d;
      rcnt_q <= rcnt_d;
      done_q <= done_d;
    end
  end

  assign conv_start = (st_q == ST_ISSUE);
  assign conv_ch    = ch_q;
  assign seq_done   = done_q;

  // R12
  one_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch <= CHW'(NCH - 1)));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && start_req) |=> ($stable(last_q) && $stable(reps_q)));
  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(res_wr));
endmodule

// File: rtl/result_store.sv
module result_store #(
  parameter int DW    = 10,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_rd, full;

  assign full     = (cnt_q == (AW+1)'(DEPTH));
  assign rd_valid = (cnt_q != '0);
  assign do_rd    = rd_en && rd_valid;
  assign rd_data  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_en) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      cnt_d = cnt_q + (AW+1)'(wr_en) - (AW+1)'(do_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full && !rd_en));
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_valid && !wr_en && !clr) |=> $stable(rp_q) && !rd_valid);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH    = 12,
  parameter int DW     = 10,
  parameter int REPEAT = 8,
  parameter int MIDCH  = 6,
  parameter int DEPTH  = 16,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic [1:0]     cfg_scan,
  input  logic [CHW-1:0] cfg_chsel,
  input  logic           cfg_refpin,
  input  logic           cfg_extclk,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           seq_done,
  input  logic           rd_en,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data
);
  localparam int RW = $clog2(REPEAT + 1);

  logic [CHW-1:0] p_first, p_last;
  logic [RW-1:0]  p_reps;
  logic           res_wr, seq_clr;

  scan_plan #(.NCH(NCH), .CHW(CHW), .REPEAT(REPEAT), .MIDCH(MIDCH), .RW(RW)) u_plan (
    .scan(cfg_scan), .sel(cfg_chsel), .refpin(cfg_refpin), .extclk(cfg_extclk),
    .first(p_first), .last(p_last), .reps(p_reps)
  );

  scan_seq_fsm #(.NCH(NCH), .CHW(CHW), .RW(RW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .plan_first(p_first), .plan_last(p_last), .plan_reps(p_reps),
    .conv_done(conv_done), .conv_start(conv_start), .conv_ch(conv_ch),
    .res_wr(res_wr), .seq_clr(seq_clr), .seq_done(seq_done)
  );

  result_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .wr_en(res_wr), .wr_data(conv_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [1:0] cfg_scan = 2'b11;
  logic [3:0] cfg_chsel = 4'd0;
  logic       cfg_refpin = 1'b0, cfg_extclk = 1'b0;
  logic       conv_start, conv_done = 1'b0;
  logic [3:0] conv_ch;
  logic [9:0] conv_data = '0;
  logic       seq_done, rd_en = 1'b0, rd_valid;
  logic [9:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int model_idx = 0;
  int extra_starts = 0;
  logic [9:0] exp_q[$];
  string cur_tag = "R9";

  always #2 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_scan(cfg_scan),
    .cfg_chsel(cfg_chsel), .cfg_refpin(cfg_refpin), .cfg_extclk(cfg_extclk),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .seq_done(seq_done), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model: result = {channel, running index}
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (conv_start) begin
        logic [3:0] ch;
        ch = conv_ch;
        repeat (LAT) @(negedge clk);
        conv_data = {ch, 6'(model_idx)};
        model_idx++;
        conv_done = 1'b1;
      end
    end
  end

  // monitor: pop and compare every result the store offers
  initial begin
    forever begin
      @(negedge clk);
      rd_en = 1'b0;
      if (rst_n && rd_valid) begin
        if (exp_q.size() == 0) check({cur_tag, " extra result"}, int'(rd_data), -1);
        else check({cur_tag, " result"}, int'(rd_data), int'(exp_q.pop_front()));
        rd_en = 1'b1;
      end
    end
  end

  // driver: compute the expected order from the requirements, then run
  task automatic run_seq(input string tag, input logic [1:0] sc, input int sel,
                         input logic rf, input logic ex, input logic poke);
    int s, top, lo, hi, n;
    s   = (sel > 11) ? 11 : sel;
    top = rf ? 10 : 11;
    n   = 1;
    lo  = s;
    hi  = s;
    if (sc == 2'b00) begin lo = 0; hi = (s > top) ? top : s; end
    else if (sc == 2'b10) begin lo = 6; hi = (s > top) ? top : s; if (hi < 6) hi = 6; end
    else if (sc == 2'b01 && !ex) n = 8;
    begin
      int k = 0;
      for (int c = lo; c <= hi; c++)
        for (int r = 0; r < n; r++) begin
          exp_q.push_back({4'(c), 6'(k)});
          k++;
        end
    end
    cur_tag = tag;
    model_idx = 0;
    @(negedge clk);
    cfg_scan = sc; cfg_chsel = 4'(sel); cfg_refpin = rf; cfg_extclk = ex;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check("R10 done cleared", int'(seq_done), 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      cfg_scan = 2'b11; cfg_chsel = 4'd3;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      check("R11 no early done", int'(seq_done), 0);
    end
    while (!seq_done) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " all results read"}, exp_q.size(), 0);
    check("R8 store drained", int'(rd_valid), 0);
    check("R10 done held", int'(seq_done), 1);
    exp_q.delete();
  endtask

  // R12: count pulses while idle
  always @(negedge clk) if (rst_n && conv_start && seq_done) extra_starts++;

  initial begin
    repeat (3) @(negedge clk);
    check("R9 conv_ch", int'(conv_ch), 0);
    check("R9 conv_start", int'(conv_start), 0);
    check("R9 seq_done", int'(seq_done), 0);
    check("R9 rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 conv_ch after release", int'(conv_ch), 0);
    run_seq("R1 up to 5", 2'b00, 5, 1'b0, 1'b0, 1'b0);
    run_seq("R1 up to 0", 2'b00, 0, 1'b0, 1'b0, 1'b0);
    run_seq("R2 up clamp", 2'b00, 15, 1'b0, 1'b0, 1'b0);
    run_seq("R6 up ref", 2'b00, 11, 1'b1, 1'b0, 1'b0);
    run_seq("R3 repeat", 2'b01, 3, 1'b0, 1'b0, 1'b0);
    run_seq("R7 ext single", 2'b01, 4, 1'b0, 1'b1, 1'b0);
    run_seq("R4 mid to 9", 2'b10, 9, 1'b0, 1'b0, 1'b0);
    run_seq("R4 mid low", 2'b10, 2, 1'b0, 1'b0, 1'b0);
    run_seq("R6 mid ref", 2'b10, 13, 1'b1, 1'b0, 1'b0);
    run_seq("R5 single", 2'b11, 7, 1'b0, 1'b0, 1'b0);
    run_seq("R2 single clamp", 2'b11, 14, 1'b0, 1'b0, 1'b0);
    run_seq("R11 busy start", 2'b00, 11, 1'b0, 1'b0, 1'b1);
    // R8: read while empty has no effect
    rd_en = 1'b1;
    @(negedge clk);
    check("R8 empty read", int'(rd_valid), 0);
    check("R12 no start while idle", extra_starts, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule